// File: doc/BRIEF.md
# Configuration Space Header Register File

This block holds the 64-byte standard header of a device configuration space and serves it through a small request/response register port. A request presents a byte offset, an access size of 1, 2 or 4 bytes, a write flag and write data in a single cycle. Each request is answered exactly `LAT` cycles later by a one-cycle response pulse. The response carries the read data and an error bit. Requests may be issued back to back. Their effect on state is committed at the clock edge that accepts them, so a read in the next cycle sees the new value.

The header holds fixed identity and class words, a writable command and status pair, cache line size, latency timer and interrupt line, six base address registers and an expansion ROM base register. Every reset value comes from a parameter. A base address register supports the sizing probe: writing all ones makes it return a size mask. Its low type bits can never be changed by software. After a real address is written, the register opens a decode window. The window is reported on `win_enable` and `win_base` as an enable flag and a translated base address, with one offset added for I/O registers and another for memory registers. Each window size must be zero or a power of two, and any other value stops elaboration.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset every header field holds its parameter value, every decode window is disabled with base 0, and no response is pending.
- R2: Each request accepted with `req_valid` high produces exactly one `rsp_valid` pulse `LAT` cycles later, with no other pulses. Back-to-back requests are answered in order. A read issued in the cycle after a write sees the written value.
- R3: A request is rejected with `rsp_error` = 1 if its size is not 1, 2 or 4, or if offset + size exceeds 64 (this covers every access at or above offset 0x40). A rejected request returns `rsp_rdata` = 0 and changes no state.
- R4: A read returns the header bytes starting at the offset, in little-endian order in the low `size` bytes of `rsp_rdata`, with the upper bytes zero. Offsets 0x34 to 0x3B read as zero. A write response carries `rsp_rdata` = 0.
- R5: A 4-byte write of 0xFFFFFFFF to a base address register (offsets 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24 for registers 0 to 5) makes its address bits read back as ~(size-1) while its type bits are kept. A register with size 0 reads back only its type bits.
- R6: Any other 4-byte write to a base address register keeps the type bits from the old value and replaces the remaining bits with the written data. The type bits are bits 1:0 when bit 0 is 1 (I/O) and bits 3:0 when bit 0 is 0 (memory).
- R7: A non-probe write that leaves nonzero address bits enables that register's window. The window base is the address bits plus `IO_BASE` for I/O or `MEM_BASE` for memory. A write leaving zero address bits, and a sizing probe, leave the window as it was.
- R8: A 4-byte write of 0xFFFFFFFE to the ROM base register (0x30) makes it read 0xFFFFFFFF. Any other 4-byte value there is stored unchanged.
- R9: 1-byte writes update the interrupt line (0x3C), cache line size (0x0C) or latency timer (0x0D). At 0x08, 0x0B, 0x3D, 0x3E and 0x3F they are accepted without error and change nothing. At every other offset they are rejected.
- R10: 2-byte writes are accepted at 0x04 (command), 0x06 (status) and 0x0C, where the low byte goes to cache line size and the high byte to latency timer. At every other offset they are rejected.
- R11: A 4-byte write at 0x04 replaces the 16-bit command and leaves status unchanged. 4-byte writes at offsets other than 0x04, the base address registers and 0x30 are accepted without error and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into the configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response pulse, `LAT` cycles after the request |
| rsp_error | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, little-endian, zero for writes and errors |
| win_enable | output | 6 | Decode window enable, one bit per base address register |
| win_base | output | 6*WIN_W | Translated window bases, register i at bits [i*WIN_W +: WIN_W] |

## Verification
Almost all internal state is observable only through reads, so a wrongly held field appears in the read response `LAT` cycles after the read is issued. The bench reads every field back after each kind of write, including the ignored and rejected ones. A base address register whose type bits drift, or whose window is updated on a probe or a zero write, shows up on `win_enable`/`win_base` in the cycle after the offending write. Those outputs are compared with the reference model on every clock. A response pipeline that drops, adds or reorders pulses is caught on the first cycle where `rsp_valid` disagrees with the model's queue of due responses.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int NUM_BARS  = 6;
  localparam int HDR_BYTES = 64;
  localparam int HDR_BITS  = HDR_BYTES * 8;

  localparam logic [7:0] OFF_CMD   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h06;
  localparam logic [7:0] OFF_REV   = 8'h08;
  localparam logic [7:0] OFF_CLASS = 8'h0B;
  localparam logic [7:0] OFF_CLS   = 8'h0C;
  localparam logic [7:0] OFF_LAT   = 8'h0D;
  localparam logic [7:0] OFF_BAR0  = 8'h10;
  localparam logic [7:0] OFF_ROM   = 8'h30;
  localparam logic [7:0] OFF_INTL  = 8'h3C;
  localparam logic [7:0] OFF_INTP  = 8'h3D;
  localparam logic [7:0] OFF_MGNT  = 8'h3E;
  localparam logic [7:0] OFF_MLAT  = 8'h3F;

  localparam logic [31:0] IO_TYPE_MASK  = 32'h0000_0003;
  localparam logic [31:0] MEM_TYPE_MASK = 32'h0000_000F;
  localparam logic [31:0] SIZE_PROBE    = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_PROBE     = 32'hFFFF_FFFE;

  typedef struct packed {
    logic                cmd;
    logic                stat;
    logic                cls;
    logic                lat;
    logic                intl;
    logic                rom;
    logic [NUM_BARS-1:0] bar;
  } wr_sel_t;

  function automatic logic size_is_legal(logic [31:0] v);
    return (v & (v - 32'd1)) == 32'd0;
  endfunction

endpackage

// File: rtl/cfg_access_dec.sv
module cfg_access_dec
  import cfg_hdr_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [7:0] req_offset,
  input  logic [2:0] req_size,
  output logic       dec_err,
  output wr_sel_t    dec_sel
);

  logic       size_ok;
  logic       range_ok;
  logic [8:0] end_off;

  assign end_off  = {1'b0, req_offset} + {6'd0, req_size};
  assign size_ok  = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign range_ok = end_off <= 9'(HDR_BYTES);

  always_comb begin
    dec_sel = '0;
    dec_err = 1'b0;
    if (req_valid) begin
      if (!size_ok || !range_ok) begin
        dec_err = 1'b1;
      end else if (req_write) begin
        case (req_size)
          3'd1: begin
            case (req_offset)
              OFF_INTL: dec_sel.intl = 1'b1;
              OFF_CLS:  dec_sel.cls  = 1'b1;
              OFF_LAT:  dec_sel.lat  = 1'b1;
              OFF_REV, OFF_CLASS, OFF_INTP, OFF_MGNT, OFF_MLAT: ;
              default:  dec_err = 1'b1;
            endcase
          end
          3'd2: begin
            case (req_offset)
              OFF_CMD:  dec_sel.cmd  = 1'b1;
              OFF_STAT: dec_sel.stat = 1'b1;
              OFF_CLS: begin
                dec_sel.cls = 1'b1;
                dec_sel.lat = 1'b1;
              end
              default:  dec_err = 1'b1;
            endcase
          end
          default: begin
            dec_sel.cmd = (req_offset == OFF_CMD);
            dec_sel.rom = (req_offset == OFF_ROM);
            for (int i = 0; i < NUM_BARS; i++) begin
              dec_sel.bar[i] = (req_offset == OFF_BAR0 + 8'(4 * i));
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter logic [31:0] INIT     = 32'h0,
  parameter logic [31:0] SIZE     = 32'h0,
  parameter int          WIN_W    = 40,
  parameter logic [WIN_W-1:0] IO_BASE  = '0,
  parameter logic [WIN_W-1:0] MEM_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      bar_q,
  output logic             win_en,
  output logic [WIN_W-1:0] win_base
);

  localparam logic [31:0] SIZE_MASK = ~(SIZE - 32'd1);
  localparam logic [31:0] TMASK     = INIT[0] ? IO_TYPE_MASK : MEM_TYPE_MASK;
  localparam int          PAD_W     = WIN_W - 32;

  if (!size_is_legal(SIZE)) begin : g_bad_size
    $error("cfg_bar_slot: window size must be zero or a power of two");
  end

  logic             is_io;
  logic [31:0]      type_mask;
  logic [31:0]      addr_bits;
  logic [31:0]      bar_d;
  logic             win_en_d;
  logic [WIN_W-1:0] win_base_d;

  assign is_io     = bar_q[0];
  assign type_mask = is_io ? IO_TYPE_MASK : MEM_TYPE_MASK;

  always_comb begin
    bar_d      = bar_q;
    win_en_d   = win_en;
    win_base_d = win_base;
    addr_bits  = wdata & ~type_mask;
    if (wr_en) begin
      if (wdata == SIZE_PROBE) begin
        bar_d = (SIZE_MASK & ~type_mask) | (bar_q & type_mask);
      end else begin
        bar_d = addr_bits | (bar_q & type_mask);
        if (addr_bits != 32'd0) begin
          win_en_d   = 1'b1;
          win_base_d = {{PAD_W{1'b0}}, addr_bits} + (is_io ? IO_BASE : MEM_BASE);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q    <= INIT;
      win_en   <= 1'b0;
      win_base <= '0;
    end else if (wr_en) begin
      bar_q    <= bar_d;
      win_en   <= win_en_d;
      win_base <= win_base_d;
    end
  end

  a_r6_type_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (bar_q & TMASK) == (INIT & TMASK));

  a_r5_probe_mask: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wdata == SIZE_PROBE) |=> ((bar_q & ~TMASK) == (SIZE_MASK & ~TMASK)));

  a_r7_win_from_write: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(win_en) |-> ($past(wr_en) && $past(wdata) != SIZE_PROBE));

endmodule

// File: rtl/cfg_resp_pipe.sv
module cfg_resp_pipe #(
  parameter int LAT = 2,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          in_valid,
  input  logic          in_err,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_err,
  output logic [DW-1:0] out_data
);

  localparam int CW = $clog2(LAT + 2);

  logic          v_q [LAT];
  logic          e_q [LAT];
  logic [DW-1:0] d_q [LAT];

  for (genvar k = 0; k < LAT; k++) begin : g_stage
    logic          v_in;
    logic          e_in;
    logic [DW-1:0] d_in;
    if (k == 0) begin : g_head
      assign v_in = in_valid;
      assign e_in = in_err;
      assign d_in = in_data;
    end else begin : g_body
      assign v_in = v_q[k-1];
      assign e_in = e_q[k-1];
      assign d_in = d_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[k] <= 1'b0;
        e_q[k] <= 1'b0;
        d_q[k] <= '0;
      end else begin
        v_q[k] <= v_in;
        e_q[k] <= e_in & v_in;
        if (v_in) d_q[k] <= d_in;
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_err   = e_q[LAT-1];
  assign out_data  = v_q[LAT-1] ? d_q[LAT-1] : '0;

  logic [CW-1:0] pend_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_q + CW'(in_valid) - CW'(out_valid);
  end

  a_r2_no_orphan_resp: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (pend_q != '0));

  a_r2_pend_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_q <= CW'(LAT));

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter int                     LAT           = 2,
  parameter int                     WIN_W         = 40,
  parameter logic [WIN_W-1:0]       IO_BASE       = 40'h80_0000_0000,
  parameter logic [WIN_W-1:0]       MEM_BASE      = 40'h40_0000_0000,
  parameter logic [31:0]            ID_INIT       = 32'h5A17_C0DE,
  parameter logic [31:0]            CMDSTAT_INIT  = 32'h0010_0000,
  parameter logic [31:0]            CLASSREV_INIT = 32'h0280_0003,
  parameter logic [31:0]            MISC_INIT     = 32'h0000_4010,
  parameter logic [NUM_BARS*32-1:0] BAR_INITS     = {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0},
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES     = {32'h0, 32'h80, 32'h0, 32'h0010_0000, 32'h100, 32'h1000},
  parameter logic [31:0]            CARDBUS_INIT  = 32'h0,
  parameter logic [31:0]            SUBSYS_INIT   = 32'h0001_C0DE,
  parameter logic [31:0]            ROM_INIT      = 32'h0,
  parameter logic [31:0]            INTR_INIT     = 32'h0000_010B
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [7:0]                req_offset,
  input  logic [2:0]                req_size,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_error,
  output logic [31:0]               rsp_rdata,
  output logic [NUM_BARS-1:0]       win_enable,
  output logic [NUM_BARS*WIN_W-1:0] win_base
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // access decode
  logic    dec_err;
  wr_sel_t sel;

  cfg_access_dec u_dec (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_offset (req_offset),
    .req_size   (req_size),
    .dec_err    (dec_err),
    .dec_sel    (sel)
  );

  // writable header fields
  logic [15:0] cmd_q,  cmd_d;
  logic [15:0] stat_q, stat_d;
  logic [7:0]  cls_q,  cls_d;
  logic [7:0]  lat_q,  lat_d;
  logic [7:0]  intl_q, intl_d;
  logic [31:0] rom_q,  rom_d;
  logic        fld_en;

  assign fld_en = sel.cmd | sel.stat | sel.cls | sel.lat | sel.intl | sel.rom;

  always_comb begin
    cmd_d  = sel.cmd  ? req_wdata[15:0] : cmd_q;
    stat_d = sel.stat ? req_wdata[15:0] : stat_q;
    cls_d  = sel.cls  ? req_wdata[7:0]  : cls_q;
    lat_d  = lat_q;
    if (sel.lat) lat_d = (req_size == 3'd2) ? req_wdata[15:8] : req_wdata[7:0];
    intl_d = sel.intl ? req_wdata[7:0] : intl_q;
    rom_d  = rom_q;
    if (sel.rom) rom_d = (req_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : req_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMDSTAT_INIT[15:0];
      stat_q <= CMDSTAT_INIT[31:16];
      cls_q  <= MISC_INIT[7:0];
      lat_q  <= MISC_INIT[15:8];
      intl_q <= INTR_INIT[7:0];
      rom_q  <= ROM_INIT;
    end else if (fld_en) begin
      cmd_q  <= cmd_d;
      stat_q <= stat_d;
      cls_q  <= cls_d;
      lat_q  <= lat_d;
      intl_q <= intl_d;
      rom_q  <= rom_d;
    end
  end

  // base address registers
  logic [31:0]            bar_val [NUM_BARS];
  logic [NUM_BARS*32-1:0] bar_flat;

  for (genvar gi = 0; gi < NUM_BARS; gi++) begin : g_bar
    cfg_bar_slot #(
      .INIT     (BAR_INITS[gi*32 +: 32]),
      .SIZE     (BAR_SIZES[gi*32 +: 32]),
      .WIN_W    (WIN_W),
      .IO_BASE  (IO_BASE),
      .MEM_BASE (MEM_BASE)
    ) u_slot (
      .clk      (clk),
      .rst_ni   (rst_ni),
      .wr_en    (sel.bar[gi]),
      .wdata    (req_wdata),
      .bar_q    (bar_val[gi]),
      .win_en   (win_enable[gi]),
      .win_base (win_base[gi*WIN_W +: WIN_W])
    );
    assign bar_flat[gi*32 +: 32] = bar_val[gi];
  end

  // read path: header image, little-endian bytes
  logic [HDR_BITS-1:0] hdr;
  logic [HDR_BITS-1:0] hdr_shift;
  logic [31:0]         rd_mask;
  logic [31:0]         rsp_d;

  always_comb begin
    hdr            = '0;
    hdr[31:0]      = ID_INIT;
    hdr[63:32]     = {stat_q, cmd_q};
    hdr[95:64]     = CLASSREV_INIT;
    hdr[127:96]    = {MISC_INIT[31:16], lat_q, cls_q};
    hdr[128 +: NUM_BARS*32] = bar_flat;
    hdr[351:320]   = CARDBUS_INIT;
    hdr[383:352]   = SUBSYS_INIT;
    hdr[415:384]   = rom_q;
    hdr[511:480]   = {INTR_INIT[31:8], intl_q};
  end

  assign hdr_shift = hdr >> {req_offset[5:0], 3'b000};
  assign rd_mask   = (req_size == 3'd1) ? 32'h0000_00FF :
                     (req_size == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign rsp_d     = (req_write || dec_err) ? 32'd0 : (hdr_shift[31:0] & rd_mask);

  cfg_resp_pipe #(.LAT(LAT), .DW(32)) u_rsp (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .in_valid  (req_valid),
    .in_err    (dec_err),
    .in_data   (rsp_d),
    .out_valid (rsp_valid),
    .out_err   (rsp_error),
    .out_data  (rsp_rdata)
  );

  a_r3_err_clean: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_error |-> (rsp_valid && rsp_rdata == 32'd0));

  a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && dec_err) |=> ($stable(cmd_q) && $stable(stat_q) && $stable(cls_q) &&
                                $stable(lat_q) && $stable(intl_q) && $stable(rom_q) &&
                                $stable(bar_flat) && $stable(win_enable)));

  a_r1_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> !rsp_valid);

endmodule

// File: tb/cfg_hdr_regs_test.sv
module cfg_hdr_regs_test;

  localparam int          LAT      = 3;
  localparam int          WIN_W    = 40;
  localparam logic [39:0] IO_B     = 40'h80_0000_0000;
  localparam logic [39:0] MEM_B    = 40'h40_0000_0000;
  localparam logic [31:0] P_ID     = 32'h5A17_C0DE;
  localparam logic [31:0] P_CMDST  = 32'h0010_0000;
  localparam logic [31:0] P_CLREV  = 32'h0280_0003;
  localparam logic [31:0] P_MISC   = 32'h0000_4010;
  localparam logic [191:0] P_BARI  = {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0};
  localparam logic [191:0] P_BARS  = {32'h0, 32'h80, 32'h0, 32'h0010_0000, 32'h100, 32'h1000};
  localparam logic [31:0] P_CBUS   = 32'h0;
  localparam logic [31:0] P_SUBS   = 32'h0001_C0DE;
  localparam logic [31:0] P_ROM    = 32'h0;
  localparam logic [31:0] P_INTR   = 32'h0000_010B;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [7:0]   req_offset = '0;
  logic [2:0]   req_size = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_error;
  logic [31:0]  rsp_rdata;
  logic [5:0]   win_enable;
  logic [239:0] win_base;

  cfg_hdr_regs #(
    .LAT(LAT), .WIN_W(WIN_W), .IO_BASE(IO_B), .MEM_BASE(MEM_B),
    .ID_INIT(P_ID), .CMDSTAT_INIT(P_CMDST), .CLASSREV_INIT(P_CLREV), .MISC_INIT(P_MISC),
    .BAR_INITS(P_BARI), .BAR_SIZES(P_BARS), .CARDBUS_INIT(P_CBUS), .SUBSYS_INIT(P_SUBS),
    .ROM_INIT(P_ROM), .INTR_INIT(P_INTR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .win_enable(win_enable), .win_base(win_base)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  logic [7:0]  m  [64];
  bit          we [6];
  logic [39:0] wb [6];

  typedef struct {
    int          due;
    bit          err;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic void put32(int off, logic [31:0] v);
    for (int b = 0; b < 4; b++) m[off + b] = v[8*b +: 8];
  endfunction

  function automatic logic [31:0] get(int off, int sz);
    logic [31:0] r = 32'd0;
    for (int b = 0; b < sz; b++) r[8*b +: 8] = m[off + b];
    return r;
  endfunction

  function automatic bit model_err(bit wr, int off, int sz);
    if (!(sz == 1 || sz == 2 || sz == 4)) return 1'b1;
    if (off + sz > 64) return 1'b1;
    if (!wr) return 1'b0;
    if (sz == 1)
      return !(off == 'h3C || off == 'h0C || off == 'h0D || off == 'h08 ||
               off == 'h0B || off == 'h3D || off == 'h3E || off == 'h3F);
    if (sz == 2) return !(off == 'h04 || off == 'h06 || off == 'h0C);
    return 1'b0;
  endfunction

  function automatic void model_write(int off, int sz, logic [31:0] d);
    if (sz == 1) begin
      if (off == 'h3C || off == 'h0C || off == 'h0D) m[off] = d[7:0];
    end else if (sz == 2) begin
      m[off] = d[7:0];
      m[off + 1] = d[15:8];
    end else if (off == 'h04) begin
      m[4] = d[7:0];
      m[5] = d[15:8];
    end else if (off == 'h30) begin
      put32('h30, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d);
    end else if (off >= 'h10 && off <= 'h24 && (off % 4) == 0) begin
      int          n;
      logic [31:0] old;
      logic [31:0] msk;
      logic [31:0] sz32;
      logic [31:0] nv;
      n    = (off - 'h10) / 4;
      old  = get(off, 4);
      msk  = old[0] ? 32'h3 : 32'hF;
      sz32 = P_BARS[n*32 +: 32];
      if (d == 32'hFFFF_FFFF) begin
        nv = ~(sz32 - 32'd1);
      end else begin
        nv = d & ~msk;
        if (nv != 0) begin
          we[n] = 1'b1;
          wb[n] = {8'h00, nv} + (old[0] ? IO_B : MEM_B);
        end
      end
      put32(off, (nv & ~msk) | (old & msk));
    end
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one request at a negedge, return at the next negedge
  task automatic issue(bit wr, int off, int sz, logic [31:0] d, string tag);
    bit e;
    e = model_err(wr, off, sz);
    req_valid  = 1'b1;
    req_write  = wr;
    req_offset = 8'(off);
    req_size   = 3'(sz);
    req_wdata  = d;
    q.push_back('{cyc + LAT, e, (wr || e) ? 32'd0 : get(off, sz), tag});
    @(posedge clk);
    if (wr && !e) model_write(off, sz, d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (armed) begin
      logic [5:0]   ee;
      logic [239:0] eb;
      if (q.size() != 0 && q[0].due == cyc) begin
        chk(rsp_valid && rsp_error == q[0].err && rsp_rdata == q[0].data, q[0].tag,
            "response {valid,err,data}", {31'd0, rsp_valid, rsp_error, rsp_rdata},
            {31'd0, 1'b1, q[0].err, q[0].data});
        void'(q.pop_front());
      end else begin
        chk(!rsp_valid, "R2", "unexpected response", {63'd0, rsp_valid}, 64'd0);
      end
      for (int i = 0; i < 6; i++) begin
        ee[i] = we[i];
        eb[i*40 +: 40] = wb[i];
      end
      chk(win_enable == ee, "R7", "window enables", {58'd0, win_enable}, {58'd0, ee});
      for (int i = 0; i < 6; i++)
        chk(win_base[i*40 +: 40] == eb[i*40 +: 40], "R7", "window base",
            {24'd0, win_base[i*40 +: 40]}, {24'd0, eb[i*40 +: 40]});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic read_all(string tag);
    for (int k = 0; k < 16; k++) issue(1'b0, 4 * k, 4, 32'd0, tag);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) m[k] = 8'h00;
    put32('h00, P_ID);   put32('h04, P_CMDST); put32('h08, P_CLREV); put32('h0C, P_MISC);
    for (int i = 0; i < 6; i++) put32('h10 + 4 * i, P_BARI[i*32 +: 32]);
    put32('h28, P_CBUS); put32('h2C, P_SUBS);  put32('h30, P_ROM);   put32('h3C, P_INTR);
    for (int i = 0; i < 6; i++) begin
      we[i] = 1'b0;
      wb[i] = '0;
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset
    chk(win_enable == 6'd0 && win_base == '0, "R1", "windows after reset",
        {58'd0, win_enable}, 64'd0);
    chk(!rsp_valid, "R1", "no response after reset", {63'd0, rsp_valid}, 64'd0);
    armed = 1'b1;

    // R1 / R2: read whole header back to back
    read_all("R1");

    // R4: narrow and unaligned reads
    issue(1'b0, 'h01, 1, 32'd0, "R4");
    issue(1'b0, 'h02, 2, 32'd0, "R4");
    issue(1'b0, 'h3D, 2, 32'd0, "R4");
    issue(1'b0, 'h0A, 4, 32'd0, "R4");
    issue(1'b0, 'h35, 4, 32'd0, "R4");

    // R3: rejected sizes and ranges
    issue(1'b0, 'h00, 3, 32'd0, "R3");
    issue(1'b0, 'h00, 0, 32'd0, "R3");
    issue(1'b0, 'h40, 1, 32'd0, "R3");
    issue(1'b0, 'h3E, 4, 32'd0, "R3");
    issue(1'b1, 'h80, 4, 32'h1234_5678, "R3");
    issue(1'b1, 'h3C, 2, 32'h0000_7777, "R3");
    issue(1'b0, 'h3C, 4, 32'd0, "R3");

    // R9: byte writes
    issue(1'b1, 'h3C, 1, 32'h0000_005A, "R9");
    issue(1'b0, 'h3C, 1, 32'd0, "R9");
    issue(1'b1, 'h0C, 1, 32'h0000_0011, "R9");
    issue(1'b1, 'h0D, 1, 32'h0000_0022, "R9");
    issue(1'b1, 'h08, 1, 32'h0000_00EE, "R9");
    issue(1'b1, 'h0B, 1, 32'h0000_00EE, "R9");
    issue(1'b1, 'h3D, 1, 32'h0000_00EE, "R9");
    issue(1'b1, 'h3F, 1, 32'h0000_00EE, "R9");
    issue(1'b1, 'h00, 1, 32'h0000_00EE, "R9");
    issue(1'b1, 'h10, 1, 32'h0000_00EE, "R9");
    issue(1'b0, 'h08, 4, 32'd0, "R9");
    issue(1'b0, 'h0C, 4, 32'd0, "R9");
    issue(1'b0, 'h3C, 4, 32'd0, "R9");
    issue(1'b0, 'h00, 4, 32'd0, "R9");

    // R10: halfword writes
    issue(1'b1, 'h04, 2, 32'h0000_0147, "R10");
    issue(1'b1, 'h06, 2, 32'h0000_1234, "R10");
    issue(1'b1, 'h0C, 2, 32'h0000_BEEF, "R10");
    issue(1'b1, 'h02, 2, 32'h0000_AAAA, "R10");
    issue(1'b1, 'h08, 2, 32'h0000_AAAA, "R10");
    issue(1'b0, 'h04, 4, 32'd0, "R10");
    issue(1'b0, 'h0C, 4, 32'd0, "R10");
    issue(1'b0, 'h00, 4, 32'd0, "R10");

    // R11: word writes to command and read-only words
    issue(1'b1, 'h04, 4, 32'hDEAD_0006, "R11");
    issue(1'b1, 'h00, 4, 32'hFFFF_FFFF, "R11");
    issue(1'b1, 'h08, 4, 32'hFFFF_FFFF, "R11");
    issue(1'b1, 'h3C, 4, 32'hFFFF_FFFF, "R11");
    issue(1'b1, 'h28, 4, 32'hFFFF_FFFF, "R11");
    read_all("R11");

    // R5: sizing probes on every register
    for (int i = 0; i < 6; i++) issue(1'b1, 'h10 + 4 * i, 4, 32'hFFFF_FFFF, "R5");
    for (int i = 0; i < 6; i++) issue(1'b0, 'h10 + 4 * i, 4, 32'd0, "R5");

    // R6 / R7: programming addresses
    issue(1'b1, 'h10, 4, 32'h1234_5ABC, "R6");
    issue(1'b1, 'h14, 4, 32'h0000_C0DE, "R6");
    issue(1'b1, 'h18, 4, 32'hA000_000F, "R6");
    issue(1'b1, 'h1C, 4, 32'h0000_0000, "R7");
    issue(1'b1, 'h24, 4, 32'h0000_0003, "R7");
    issue(1'b1, 'h20, 4, 32'h0000_0F06, "R6");
    for (int i = 0; i < 6; i++) issue(1'b0, 'h10 + 4 * i, 4, 32'd0, "R6");
    issue(1'b1, 'h10, 4, 32'hFFFF_FFFF, "R7");
    issue(1'b0, 'h10, 4, 32'd0, "R5");
    issue(1'b1, 'h10, 4, 32'h0000_0000, "R7");
    issue(1'b0, 'h10, 4, 32'd0, "R6");
    issue(1'b1, 'h14, 4, 32'h0000_0002, "R6");
    issue(1'b0, 'h14, 4, 32'd0, "R6");
    issue(1'b1, 'h14, 4, 32'hFFFF_0104, "R7");
    issue(1'b0, 'h14, 4, 32'd0, "R6");

    // R8: expansion ROM base
    issue(1'b1, 'h30, 4, 32'hFFFF_FFFE, "R8");
    issue(1'b0, 'h30, 4, 32'd0, "R8");
    issue(1'b1, 'h30, 4, 32'h000C_0001, "R8");
    issue(1'b0, 'h30, 4, 32'd0, "R8");
    issue(1'b1, 'h30, 4, 32'hFFFF_FFFF, "R8");
    issue(1'b0, 'h30, 2, 32'd0, "R8");

    // R2: gaps between requests, then idle
    repeat (2) @(negedge clk);
    issue(1'b0, 'h3C, 1, 32'd0, "R2");
    @(negedge clk);
    issue(1'b0, 'h04, 2, 32'd0, "R2");

    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule